// File: doc/BRIEF.md
# Per-Bit Input Interrupt Trigger Bank

This block watches a bank of input lines that are already synchronous to the system clock. It raises a sticky status flag for each line whose trigger condition is met. Each line has its own trigger mode: falling edge, rising edge, any edge, low level or high level. The mode is encoded across three per-bit select registers. A per-bit enable mask gates the flags into one aggregated interrupt output. The flags latch whether or not the line is enabled.

Software reaches the bank through a small register port. A write takes effect at the next clock edge, and a read is combinational from the address. The status register is write-one-to-clear. A line that triggers on a level keeps its flag asserted for as long as the level persists. A trigger event that lands in the same cycle as a clear wins.

Top module: `irq_trig_bank`

## Requirements
- R1: After reset the enable register is all 0, the polarity select is all 1, the level select is all 1, the dual-edge select is all 0, the status is all 0 and `irq_out` is 0. Every line therefore starts in level-high mode. The previous-sample register of each line resets to 0.
- R2: Registers sit at these byte offsets: enable 0x00, polarity select 0x04 (1 = rising/high), level select 0x08 (1 = level, 0 = edge), dual-edge select 0x0C and status 0x10. Bit i of each register belongs to line i. The enable and select registers read back what was written. Any other address reads 0.
- R3: Polarity 0, level 0 and dual 0 is falling-edge mode. A line sampled 1 on one edge and 0 on the next sets its status bit at that second edge.
- R4: Polarity 1, level 0 and dual 0 is rising-edge mode. A 0-to-1 change between consecutive edges sets the status bit.
- R5: Level 0 with dual 1 sets the status bit on any change of the line, whatever the polarity bit holds.
- R6: Level 1 with polarity 0 is level-low mode, and level 1 with polarity 1 is level-high mode. The status bit is set at every edge at which the line holds that level, so a clear does not stick while the level persists.
- R7: A status bit stays set until it is cleared. Writing 0 to a status bit leaves it unchanged.
- R8: Writing 1 to a status bit clears it at that edge, unless a trigger event for the same bit occurs at the same edge, in which case the bit stays set.
- R9: Status bits latch regardless of the enable mask. `irq_out` is 1 exactly when some bit has both its status and its enable set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | WIDTH | Synchronised input lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | WIDTH | Register write data |
| reg_rdata | output | WIDTH | Register read data for `reg_addr` |
| irq_out | output | 1 | Aggregated interrupt |

## Verification
The bench builds the bank with WIDTH = 8 and ADDR_W = 5. Eight lines are enough to give every trigger mode its own bit at once, with spare bits repeating the rising, falling and dual-edge modes. The dual-edge bits use both polarity settings. An enable mask of 0x0F leaves some flagged lines enabled and others masked, so the effect of masking is visible on `irq_out` within the same vector walk. With five address bits, the offset just past the status register can be read to check the read of an unmapped address.

// File: rtl/irq_trig_pkg.sv
`timescale 1ns/1ps
package irq_trig_pkg;
   localparam int OFS_EN   = 'h00;
   localparam int OFS_POL  = 'h04;
   localparam int OFS_LVL  = 'h08;
   localparam int OFS_DUAL = 'h0C;
   localparam int OFS_FLAG = 'h10;

   typedef enum logic [2:0] {
      SEL_EN, SEL_POL, SEL_LVL, SEL_DUAL, SEL_FLAG, SEL_NONE
   } reg_sel_e;

   function automatic reg_sel_e decode_addr(input logic [31:0] a);
      case (a)
         32'(OFS_EN):   return SEL_EN;
         32'(OFS_POL):  return SEL_POL;
         32'(OFS_LVL):  return SEL_LVL;
         32'(OFS_DUAL): return SEL_DUAL;
         32'(OFS_FLAG): return SEL_FLAG;
         default:       return SEL_NONE;
      endcase
   endfunction
endpackage

// File: rtl/irq_line_sampler.sv
`timescale 1ns/1ps
module irq_line_sampler #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] line_in,
   output logic [WIDTH-1:0] rise,
   output logic [WIDTH-1:0] fall
);
   logic [WIDTH-1:0] last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= '0;
      else        last_q <= line_in;
   end

   assign rise = line_in & ~last_q;
   assign fall = ~line_in & last_q;
endmodule

// File: rtl/irq_mode_select.sv
`timescale 1ns/1ps
module irq_mode_select #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] pol,
   input  logic [WIDTH-1:0] lvl,
   input  logic [WIDTH-1:0] dual,
   input  logic [WIDTH-1:0] line_in,
   input  logic [WIDTH-1:0] rise,
   input  logic [WIDTH-1:0] fall,
   output logic [WIDTH-1:0] hit
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic level_hit, edge_hit;
      assign level_hit = pol[i] ? line_in[i] : ~line_in[i];
      assign edge_hit  = dual[i] ? (rise[i] | fall[i])
                                 : (pol[i] ? rise[i] : fall[i]);
      assign hit[i]    = lvl[i] ? level_hit : edge_hit;
   end
endmodule

// File: rtl/irq_trig_regs.sv
`timescale 1ns/1ps
module irq_trig_regs
   import irq_trig_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [WIDTH-1:0]  reg_wdata,
   input  logic [WIDTH-1:0]  hit,
   output logic [WIDTH-1:0]  en_q,
   output logic [WIDTH-1:0]  pol_q,
   output logic [WIDTH-1:0]  lvl_q,
   output logic [WIDTH-1:0]  dual_q,
   output logic [WIDTH-1:0]  flag_q,
   output logic [WIDTH-1:0]  reg_rdata
);
   reg_sel_e         sel;
   logic [WIDTH-1:0] clr;

   assign sel = decode_addr(32'(reg_addr));
   assign clr = (reg_wr && sel == SEL_FLAG) ? reg_wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= '0;
         pol_q  <= '1;
         lvl_q  <= '1;
         dual_q <= '0;
         flag_q <= '0;
      end else begin
         if (reg_wr && sel == SEL_EN)   en_q   <= reg_wdata;
         if (reg_wr && sel == SEL_POL)  pol_q  <= reg_wdata;
         if (reg_wr && sel == SEL_LVL)  lvl_q  <= reg_wdata;
         if (reg_wr && sel == SEL_DUAL) dual_q <= reg_wdata;
         flag_q <= (flag_q & ~clr) | hit;
      end
   end

   always_comb begin
      case (sel)
         SEL_EN:   reg_rdata = en_q;
         SEL_POL:  reg_rdata = pol_q;
         SEL_LVL:  reg_rdata = lvl_q;
         SEL_DUAL: reg_rdata = dual_q;
         SEL_FLAG: reg_rdata = flag_q;
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/irq_trig_bank.sv
`timescale 1ns/1ps
module irq_trig_bank #(
   parameter int WIDTH  = 32,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIDTH-1:0]  line_in,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [WIDTH-1:0]  reg_wdata,
   output logic [WIDTH-1:0]  reg_rdata,
   output logic              irq_out
);
   logic [WIDTH-1:0] rise, fall, hit;
   logic [WIDTH-1:0] en_q, pol_q, lvl_q, dual_q, flag_q;

   irq_line_sampler #(.WIDTH(WIDTH)) u_samp (
      .clk(clk), .rst_n(rst_n), .line_in(line_in), .rise(rise), .fall(fall)
   );

   irq_mode_select #(.WIDTH(WIDTH)) u_sel (
      .pol(pol_q), .lvl(lvl_q), .dual(dual_q), .line_in(line_in),
      .rise(rise), .fall(fall), .hit(hit)
   );

   irq_trig_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .hit(hit), .en_q(en_q), .pol_q(pol_q),
      .lvl_q(lvl_q), .dual_q(dual_q), .flag_q(flag_q), .reg_rdata(reg_rdata)
   );

   assign irq_out = |(flag_q & en_q);
endmodule

// File: rtl/irq_trig_bank_chk.sv
`timescale 1ns/1ps
module irq_trig_bank_chk #(
   parameter int WIDTH  = 32,
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [WIDTH-1:0]  line_in,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              irq_out,
   input logic [WIDTH-1:0]  en_q,
   input logic [WIDTH-1:0]  pol_q,
   input logic [WIDTH-1:0]  lvl_q,
   input logic [WIDTH-1:0]  dual_q,
   input logic [WIDTH-1:0]  flag_q
);
   localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(irq_trig_pkg::OFS_FLAG);

   initial begin
      param_width_chk: assert (WIDTH >= 1)
         else $error("WIDTH must be at least 1");
      param_addr_chk: assert (ADDR_W >= 5 && ADDR_W <= 32)
         else $error("ADDR_W must lie in 5..32");
   end

   logic [WIDTH-1:0] prev_q;
   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= line_in;
   end

   logic [WIDTH-1:0] fall_m, rise_m, dual_m, lvl_m;
   assign fall_m = ~lvl_q & ~dual_q & ~pol_q & prev_q & ~line_in;
   assign rise_m = ~lvl_q & ~dual_q & pol_q & ~prev_q & line_in;
   assign dual_m = ~lvl_q & dual_q & (prev_q ^ line_in);
   assign lvl_m  = lvl_q & ~(pol_q ^ line_in);

   // R3
   fall_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag_q & $past(fall_m)) == $past(fall_m)));
   // R4
   rise_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag_q & $past(rise_m)) == $past(rise_m)));
   // R5
   dual_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag_q & $past(dual_m)) == $past(dual_m)));
   // R6
   lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag_q & $past(lvl_m)) == $past(lvl_m)));
   // R7
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == FLAG_ADDR) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
   // R9
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> !irq_out);
endmodule

bind irq_trig_bank irq_trig_bank_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .line_in(line_in), .reg_wr(reg_wr),
   .reg_addr(reg_addr), .irq_out(irq_out), .en_q(en_q), .pol_q(pol_q),
   .lvl_q(lvl_q), .dual_q(dual_q), .flag_q(flag_q)
);

// File: tb/irq_trig_bank_test.sv
`timescale 1ns/1ps
module irq_trig_bank_test;
   localparam int W  = 8;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [W-1:0]  line_in = '0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [W-1:0]  reg_wdata = '0;
   logic [W-1:0]  reg_rdata;
   logic          irq_out;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_trig_bank #(.WIDTH(W), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .line_in(line_in), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_out(irq_out)
   );

   localparam logic [4:0] A_EN = 5'h00, A_POL = 5'h04, A_LVL = 5'h08,
                          A_DUAL = 5'h0C, A_FLAG = 5'h10, A_GAP = 5'h14;

   // {line_in, expected status, expected irq}; mode per bit:
   // b0 fall, b1 rise, b2 any-edge, b3 level low, b4 level high,
   // b5 rise, b6 fall, b7 any-edge with polarity 0; enable 0x0F
   localparam int NV = 11;
   localparam logic [23:0] VEC [NV] = '{
      24'hFF_BE_01, 24'h00_DD_01, 24'h00_08_01, 24'h18_18_01,
      24'h08_10_00, 24'h0C_04_01, 24'h08_04_01, 24'hA8_A0_00,
      24'h49_80_00, 24'h08_41_01, 24'h0A_02_01
   };

   task automatic check(input string req, input logic [W-1:0] got,
                        input logic [W-1:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   initial begin
      logic [W-1:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(A_EN, v);   check("R1 enable", v, 8'h00);
      rd(A_POL, v);  check("R1 polarity", v, 8'hFF);
      rd(A_LVL, v);  check("R1 level", v, 8'hFF);
      rd(A_DUAL, v); check("R1 dual", v, 8'h00);
      rd(A_FLAG, v); check("R1 status", v, 8'h00);
      check("R1 irq", {7'd0, irq_out}, 8'h00);

      wr(A_POL, 8'h36);
      wr(A_LVL, 8'h18);
      wr(A_DUAL, 8'h84);
      wr(A_EN, 8'h0F);
      rd(A_POL, v);  check("R2 polarity readback", v, 8'h36);
      rd(A_DUAL, v); check("R2 dual readback", v, 8'h84);
      wr(A_FLAG, 8'hFF);
      rd(A_FLAG, v); check("R6 level-low survives clear", v, 8'h08);

      // vector walk: R3 R4 R5 R6 R9
      for (int k = 0; k < NV; k++) begin
         line_in = VEC[k][23:16];
         @(negedge clk);
         rd(A_FLAG, v);
         check($sformatf("R3/R4/R5/R6 status step %0d", k), v, VEC[k][15:8]);
         check($sformatf("R9 irq step %0d", k), {7'd0, irq_out}, VEC[k][7:0]);
         wr(A_FLAG, 8'hFF);
      end
      rd(A_FLAG, v); check("R8 cleared after walk", v, 8'h00);

      // R5 two any-edge bits at once
      line_in = 8'h8E;
      @(negedge clk);
      rd(A_FLAG, v); check("R5 both any-edge bits", v, 8'h84);
      // R8 partial clear
      wr(A_FLAG, 8'h04);
      rd(A_FLAG, v); check("R8 partial clear", v, 8'h80);
      // R7 zero write leaves status
      wr(A_FLAG, 8'h00);
      rd(A_FLAG, v); check("R7 zero write", v, 8'h80);
      // R8 event wins over simultaneous clear
      @(negedge clk);
      line_in = 8'h0E;
      reg_wr = 1'b1; reg_addr = A_FLAG; reg_wdata = 8'h80;
      @(negedge clk);
      reg_wr = 1'b0;
      rd(A_FLAG, v); check("R8 event beats clear", v, 8'h80);
      check("R9 masked flag keeps irq low", {7'd0, irq_out}, 8'h00);
      wr(A_EN, 8'h80);
      #1 check("R9 enabling flagged line", {7'd0, irq_out}, 8'h01);

      // R6 level high persists through clear, then clears once released
      line_in = 8'h1E;
      @(negedge clk);
      wr(A_FLAG, 8'hFF);
      rd(A_FLAG, v); check("R6 level-high re-sets", v, 8'h10);
      line_in = 8'h0E;
      @(negedge clk);
      wr(A_FLAG, 8'hFF);
      rd(A_FLAG, v); check("R6 clear after release", v, 8'h00);

      // R2 unmapped address
      wr(A_GAP, 8'h5A);
      rd(A_GAP, v); check("R2 unmapped reads zero", v, 8'h00);
      rd(A_EN, v);  check("R2 enable untouched", v, 8'h80);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule